// File: doc/BRIEF.md
# I2C Register-Write Slave with Chunked Append

This block sits on an I2C bus as a write-only target and turns bus writes into register-file updates. It matches the 7-bit device address, takes the first byte after the address as a subaddress and acknowledges every byte it accepts. Data bytes are packed into the register that the subaddress selects. Registers may be one, four or eight bytes long. A register is committed to the register file only when its last byte has arrived. Once a register completes, the write pointer moves on to the next subaddress, so a single transfer can fill several consecutive registers.

A long register does not have to be filled in one transfer. If a transfer ends partway through a register, that register is left parked: nothing is committed, and its received bytes and byte offset are kept. A later transfer that uses the reserved append subaddress resumes filling it at the saved offset. This lets a large coefficient be loaded in 4-byte pieces, and other bus traffic may run between the pieces.

The result leaves the block through a commit port: a one-cycle valid pulse carrying the subaddress and the assembled value. The first byte received lands in the most significant position. The port has no ready input and no back-pressure. I2C bytes arrive at least tens of cycles apart and clock stretching is not used, so the consumer must accept every pulse in the cycle it is raised. SCL and SDA are sampled through two-flop synchronizers. SDA is driven only as an open-drain pull-low enable.

Top module: `i2c_regwr_slave`

## Requirements
- R1: A first byte after a start equal to {7'h1B, 1'b0} (0x36) is acknowledged by pulling SDA low during the ninth clock.
- R2: A first byte with any other 7-bit address, or with the R/W bit set to 1, is not acknowledged. The slave then leaves SDA released and commits nothing until the next start condition.
- R3: After a matching address, the subaddress byte and every following data byte are acknowledged. The pull-low starts only while SCL is low.
- R4: Subaddresses 0x00 to 0x0F hold 1-byte registers. Each data byte written to one of them commits at once with that subaddress and the byte in bits [7:0].
- R5: Subaddresses 0x10 to 0x3F hold 4-byte registers and 0x40 to 0x4F hold 8-byte registers. Such a register commits once, after its last byte. The first byte received sits in the most significant byte of the value, which is right-aligned in the 64-bit data output.
- R6: In a sequential write, bytes beyond the current register's length flow into the next subaddress, including across the 0x0F/0x10 and 0x3F/0x40 length boundaries.
- R7: When a transfer stops partway through a register, that register is not committed, and the registers completed earlier in the same transfer remain committed.
- R8: A transfer whose subaddress is 0xFE (append) continues the register parked by an earlier partial write, at its saved byte offset. This holds even when transactions to other bus addresses come in between. The register commits when its last byte arrives.
- R9: Append data is acknowledged but has no effect when no register is parked. A register is parked only when a transfer ended with a partial register. A write that names any other subaddress replaces the parked register.
- R10: Data written to subaddresses 0x50 to 0xFD and 0xFF is acknowledged and never committed.
- R11: A repeated start ends the current transfer exactly as a stop does and restarts address matching.
- R12: The commit valid is a single-cycle pulse per completed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull_low | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| wr_valid | output | 1 | One-cycle commit pulse, no back-pressure |
| wr_sub | output | 8 | Subaddress of the committed register |
| wr_data | output | 64 | Assembled register value, right-aligned |

## Verification
The main function is driven with long sequential sweeps that cover every defined subaddress in each length class, each byte value computed from its register and offset. These sweeps show whether the per-class lengths, the byte ordering and the pointer advance are right. Short writes that cross a length boundary or stop partway separate a correct commit-on-completion from one that commits early or keeps partial data. Append sequences are run with a foreign-address transaction between the pieces, with a repeated start in place of a stop, and with nothing parked. These show whether the saved offset survives the gap and whether stray append data leaks into a commit. Mismatched addresses, a read bit and undefined subaddresses confirm that the acknowledge and commit behaviour is ignored or kept as the requirements say.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int LEN_W = 4;
  localparam logic [7:0] SHORT_END = 8'h10;
  localparam logic [7:0] MID_END   = 8'h40;
  localparam logic [7:0] LONG_END  = 8'h50;

  // Byte length of the register behind a subaddress; 0 means no register.
  function automatic logic [LEN_W-1:0] reg_len(input logic [7:0] s);
    if (s < SHORT_END)     return 4'd1;
    else if (s < MID_END)  return 4'd4;
    else if (s < LONG_END) return 4'd8;
    else                   return 4'd0;
  endfunction

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_RX   = 2'd1,
    LK_ACK  = 2'd2,
    LK_SKIP = 2'd3
  } link_st_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cw_link.sv
module i2cw_link
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  output logic       sda_oe,
  output logic       byte_stb,
  output logic       byte_is_sub,
  output logic [7:0] byte_val,
  output logic       xfer_end
);
  link_st_t   st;
  logic       scl_d, sda_d;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       first, sub_next;
  logic       scl_rise, scl_fall, start_c, stop_c;
  logic [7:0] full_byte;

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_c   = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c    = scl_s & scl_d & ~sda_d & sda_s;
  assign full_byte = {shreg, sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= LK_IDLE;
      scl_d       <= 1'b1;
      sda_d       <= 1'b1;
      bit_cnt     <= '0;
      shreg       <= '0;
      first       <= 1'b0;
      sub_next    <= 1'b0;
      sda_oe      <= 1'b0;
      byte_stb    <= 1'b0;
      byte_is_sub <= 1'b0;
      byte_val    <= '0;
      xfer_end    <= 1'b0;
    end else begin
      scl_d    <= scl_s;
      sda_d    <= sda_s;
      byte_stb <= 1'b0;
      xfer_end <= 1'b0;
      if (start_c) begin
        st       <= LK_RX;
        bit_cnt  <= '0;
        first    <= 1'b1;
        sda_oe   <= 1'b0;
        xfer_end <= 1'b1;
      end else if (stop_c) begin
        st       <= LK_IDLE;
        sda_oe   <= 1'b0;
        xfer_end <= 1'b1;
      end else begin
        case (st)
          LK_RX: if (scl_rise) begin
            shreg   <= full_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (first) begin
                first <= 1'b0;
                if (full_byte == {DEV_ADDR, 1'b0}) begin
                  st       <= LK_ACK;
                  sub_next <= 1'b1;
                end else begin
                  st <= LK_SKIP;
                end
              end else begin
                byte_stb    <= 1'b1;
                byte_val    <= full_byte;
                byte_is_sub <= sub_next;
                sub_next    <= 1'b0;
                st          <= LK_ACK;
              end
            end
          end
          LK_ACK: if (scl_fall) begin
            if (!sda_oe) sda_oe <= 1'b1;
            else begin
              sda_oe  <= 1'b0;
              st      <= LK_RX;
              bit_cnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  ack_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_SKIP) |-> !sda_oe);
  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);
endmodule

// File: rtl/i2cw_assembler.sv
module i2cw_assembler
  import i2cw_pkg::*;
#(
  parameter int         DATA_W     = 64,
  parameter logic [7:0] APPEND_SUB = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic              byte_is_sub,
  input  logic [7:0]        byte_val,
  input  logic              xfer_end,
  output logic              commit,
  output logic [7:0]        c_sub,
  output logic [DATA_W-1:0] c_data
);
  logic              live;
  logic [7:0]        cur_sub;
  logic [LEN_W-1:0]  cnt;
  logic [DATA_W-1:0] acc;
  logic [LEN_W-1:0]  cur_len;
  logic [DATA_W-1:0] nxt_acc;
  logic              done;
  logic [7:0]        next_sub;

  assign cur_len  = reg_len(cur_sub);
  assign nxt_acc  = {acc[DATA_W-9:0], byte_val};
  assign done     = (cnt + 4'd1) == cur_len;
  assign next_sub = cur_sub + 8'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live    <= 1'b0;
      cur_sub <= '0;
      cnt     <= '0;
      acc     <= '0;
      commit  <= 1'b0;
      c_sub   <= '0;
      c_data  <= '0;
    end else begin
      commit <= 1'b0;
      if (byte_stb && byte_is_sub) begin
        if (byte_val != APPEND_SUB) begin
          cur_sub <= byte_val;
          cnt     <= '0;
          acc     <= '0;
          live    <= reg_len(byte_val) != '0;
        end
      end else if (byte_stb && live) begin
        if (done) begin
          commit  <= 1'b1;
          c_sub   <= cur_sub;
          c_data  <= nxt_acc;
          cur_sub <= next_sub;
          cnt     <= '0;
          acc     <= '0;
          live    <= reg_len(next_sub) != '0;
        end else begin
          acc <= nxt_acc;
          cnt <= cnt + 4'd1;
        end
      end else if (xfer_end && cnt == '0) begin
        live <= 1'b0;
      end
    end
  end

  // R12
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R10
  commit_defined_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> reg_len(c_sub) != '0);
  // R5
  commit_from_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(byte_stb) && !$past(byte_is_sub));
endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'h1B,
  parameter logic [7:0] APPEND_SUB = 8'hFE,
  parameter int         MAX_BYTES  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  output logic                   sda_pull_low,
  output logic                   wr_valid,
  output logic [7:0]             wr_sub,
  output logic [MAX_BYTES*8-1:0] wr_data
);
  localparam int DATA_W = MAX_BYTES * 8;

  logic [1:0] pins_s;
  logic       stb, is_sub, xend;
  logic [7:0] bval;

  i2cw_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(pins_s)
  );

  i2cw_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(pins_s[1]), .sda_s(pins_s[0]),
    .sda_oe(sda_pull_low), .byte_stb(stb), .byte_is_sub(is_sub),
    .byte_val(bval), .xfer_end(xend)
  );

  i2cw_assembler #(.DATA_W(DATA_W), .APPEND_SUB(APPEND_SUB)) u_asm (
    .clk(clk), .rst_n(rst_n), .byte_stb(stb), .byte_is_sub(is_sub),
    .byte_val(bval), .xfer_end(xend), .commit(wr_valid),
    .c_sub(wr_sub), .c_data(wr_data)
  );

  // R11
  end_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xend |-> !stb);
endmodule

// File: tb/tb_i2c_regwr_slave.sv
module tb_i2c_regwr_slave;
  localparam int Q = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic wr_valid;
  logic [7:0] wr_sub;
  logic [63:0] wr_data;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;
  always #2 clk = ~clk;

  i2c_regwr_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull_low(sda_oe), .wr_valid(wr_valid), .wr_sub(wr_sub), .wr_data(wr_data)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0]  obs_a[$];
  logic [63:0] obs_d[$];
  logic prev_v = 1'b0;
  logic [7:0] w_reg = 8'h00;
  int w_k = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R12: valid never high on two consecutive samples
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        obs_a.push_back(wr_sub);
        obs_d.push_back(wr_data);
        if (prev_v) chk(1'b0, "R12 back-to-back valid", 1, 0);
      end
      prev_v = wr_valid;
    end
  end

  function automatic int exp_len(input logic [7:0] s);
    if (s < 8'h10) return 1;
    if (s < 8'h40) return 4;
    if (s < 8'h50) return 8;
    return 0;
  endfunction

  function automatic logic [7:0] bval(input logic [7:0] s, input int k);
    return 8'(s * 13 + k * 29 + 7);
  endfunction

  function automatic logic [63:0] exp_val(input logic [7:0] s);
    logic [63:0] v = '0;
    for (int k = 0; k < exp_len(s); k++) v = {v[55:0], bval(s, k)};
    return v;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_bus;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  // address + subaddress + n data bytes drawn from the (register, offset) walk
  task automatic write_bytes(input logic [7:0] dev8, input logic [7:0] sub, input int n,
                             input bit exp_ack, input string tag);
    bit a;
    send_byte(dev8, a);
    chk(a == exp_ack, {tag, " address ack"}, a, exp_ack);
    send_byte(sub, a);
    chk(a == exp_ack, {tag, " subaddress ack"}, a, exp_ack);
    if (sub != 8'hFE) begin w_reg = sub; w_k = 0; end
    for (int i = 0; i < n; i++) begin
      send_byte(bval(w_reg, w_k), a);
      chk(a == exp_ack, {tag, " data ack"}, a, exp_ack);
      if (exp_len(w_reg) != 0) begin
        w_k++;
        if (w_k == exp_len(w_reg)) begin w_reg = w_reg + 8'd1; w_k = 0; end
      end
    end
  endtask

  task automatic clear_obs();
    obs_a.delete(); obs_d.delete();
  endtask

  task automatic expect_seq(input logic [7:0] first, input int n, input string tag);
    chk(obs_a.size() == n, {tag, " commit count"}, obs_a.size(), n);
    for (int i = 0; i < n && i < obs_a.size(); i++) begin
      chk(obs_a[i] == 8'(first + i), {tag, " commit subaddress"}, obs_a[i], 8'(first + i));
      chk(obs_d[i] == exp_val(8'(first + i)), {tag, " commit data"}, obs_d[i], exp_val(8'(first + i)));
    end
    clear_obs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    tick(5);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 reset outputs idle", {sda_oe, wr_valid}, 0);
    rst_n = 1'b1;
    tick(5);

    // R1 R3 R4: single byte
    bus_start(); write_bytes(8'h36, 8'h05, 1, 1'b1, "R1/R3/R4"); bus_stop(); tick(4);
    expect_seq(8'h05, 1, "R4 single byte");

    // R2: wrong address, then read bit
    bus_start(); write_bytes(8'h38, 8'h07, 2, 1'b0, "R2 wrong address"); bus_stop(); tick(4);
    chk(obs_a.size() == 0, "R2 no commit on wrong address", obs_a.size(), 0);
    bus_start(); write_bytes(8'h37, 8'h07, 2, 1'b0, "R2 read bit"); bus_stop(); tick(4);
    chk(obs_a.size() == 0, "R2 no commit on read bit", obs_a.size(), 0);
    clear_obs();

    // R4 R6: every 1-byte register in one transfer
    bus_start(); write_bytes(8'h36, 8'h00, 16, 1'b1, "R6 short sweep"); bus_stop(); tick(4);
    expect_seq(8'h00, 16, "R4/R6 short sweep");

    // R5 R6: every 4-byte register
    bus_start(); write_bytes(8'h36, 8'h10, 48 * 4, 1'b1, "R5 mid sweep"); bus_stop(); tick(4);
    expect_seq(8'h10, 48, "R5/R6 mid sweep");

    // R5 R6: every 8-byte register
    bus_start(); write_bytes(8'h36, 8'h40, 16 * 8, 1'b1, "R5 long sweep"); bus_stop(); tick(4);
    expect_seq(8'h40, 16, "R5/R6 long sweep");

    // R6: crossing both length boundaries
    bus_start(); write_bytes(8'h36, 8'h0E, 2 + 4, 1'b1, "R6 cross low"); bus_stop(); tick(4);
    expect_seq(8'h0E, 3, "R6 cross 0x0F/0x10");
    bus_start(); write_bytes(8'h36, 8'h3F, 4 + 8, 1'b1, "R6 cross high"); bus_stop(); tick(4);
    expect_seq(8'h3F, 2, "R6 cross 0x3F/0x40");

    // R7: partial trailing register dropped
    bus_start(); write_bytes(8'h36, 8'h20, 6, 1'b1, "R7 partial"); bus_stop(); tick(4);
    expect_seq(8'h20, 1, "R7 only complete register kept");

    // R8: park 0x40, foreign transaction, append the rest
    bus_start(); write_bytes(8'h36, 8'h40, 4, 1'b1, "R8 first half"); bus_stop(); tick(4);
    chk(obs_a.size() == 0, "R8 no commit for half register", obs_a.size(), 0);
    bus_start(); send_byte(8'h50, a); bus_stop(); tick(4);
    chk(a == 1'b0, "R8 foreign address not acked", a, 0);
    bus_start(); write_bytes(8'h36, 8'hFE, 4, 1'b1, "R8 append"); bus_stop(); tick(4);
    expect_seq(8'h40, 1, "R8 append completes register");

    // R9: nothing parked now
    bus_start(); write_bytes(8'h36, 8'hFE, 4, 1'b1, "R9 stray append"); bus_stop(); tick(4);
    chk(obs_a.size() == 0, "R9 stray append ignored", obs_a.size(), 0);
    // R9: parked register replaced by a new subaddress, append then has nothing to extend
    bus_start(); write_bytes(8'h36, 8'h44, 4, 1'b1, "R9 park"); bus_stop(); tick(4);
    bus_start(); write_bytes(8'h36, 8'h03, 1, 1'b1, "R9 replace"); bus_stop(); tick(4);
    expect_seq(8'h03, 1, "R9 replacing write");
    bus_start(); write_bytes(8'h36, 8'hFE, 4, 1'b1, "R9 append after replace"); bus_stop(); tick(4);
    chk(obs_a.size() == 0, "R9 append after replace ignored", obs_a.size(), 0);
    clear_obs();

    // R10: undefined subaddresses
    bus_start(); write_bytes(8'h36, 8'h60, 3, 1'b1, "R10 undefined"); bus_stop(); tick(4);
    bus_start(); write_bytes(8'h36, 8'hFF, 3, 1'b1, "R10 undefined top"); bus_stop(); tick(4);
    chk(obs_a.size() == 0, "R10 undefined never commits", obs_a.size(), 0);
    clear_obs();

    // R11: repeated start ends transfer like stop
    bus_start(); write_bytes(8'h36, 8'h30, 3, 1'b1, "R11 before rstart");
    bus_rstart(); write_bytes(8'h36, 8'h07, 1, 1'b1, "R11 after rstart"); bus_stop(); tick(4);
    expect_seq(8'h07, 1, "R11 partial dropped, new transfer kept");
    bus_start(); write_bytes(8'h36, 8'h48, 4, 1'b1, "R11 park");
    bus_rstart(); write_bytes(8'h36, 8'hFE, 4, 1'b1, "R11 append"); bus_stop(); tick(4);
    expect_seq(8'h48, 1, "R8/R11 append after repeated start");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule